// File: doc/BRIEF.md
# Eight-Port Self-Routing Butterfly Fabric

This block joins eight sending ports to eight receiving ports through three routing stages of identical two-by-two switches. Each packet is a single flit. It carries a three-bit destination number in its top bits, followed by a payload and a trailer. Every switch reads exactly one destination bit and steers the flit to its lower or upper output. The stage that feeds rank s reads bit s counted from the most significant end. The switch then shifts that bit out of the header, so the next stage again finds its own bit at the top. No table or configuration is involved.

Stage s pairs column j with the column whose address differs from j only in bit position s, counted from the MSB. Stage one therefore pairs columns 4 apart, stage two pairs columns 2 apart and stage three pairs neighbouring columns. A flit that goes to the lower output of a switch lands in the lower column of the pair, so after three stages it sits in the column equal to its destination.

Each switch output holds one registered flit. Both edges of the fabric use valid/ready handshakes. When two flits want the same switch output, they take turns, and the flit that loses is held at its input.

Top module: `bfly_fabric`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released with no input, every `outValid` bit is 0.
- R2: A flit accepted on any input leaves on the output whose index equals its destination field, `inFlit[c][26:24]`, read as an unsigned number.
- R3: The delivered `outFlit` equals bits 23:0 of the accepted flit: payload in bits 23:8 and trailer in bits 7:0, both unchanged.
- R4: A flit that meets no contention and no backpressure appears on its output three clock cycles after the edge that accepted it, one cycle per stage.
- R5: While `outValid` is 1 and `outReady` is 0 on a port, that port keeps `outValid` high and `outFlit` unchanged in the next cycle.
- R6: Flits from one source to one destination leave in the order they were accepted.
- R7: Every accepted flit is delivered exactly once. A flit that loses arbitration inside the fabric is stalled, not dropped, and the stall shows as `inReady` low at its source.
- R8: With all outputs ready, the identity and the bit-complement permutations flow at one flit per port per cycle and never deassert `inReady` on a valid input.
- R9: Each switch output stores at most one flit. With every output blocked, an identity flood admits exactly 24 flits (8 ports times 3 stages) before all inputs stall.
- R10: When two inputs of a switch keep competing for one output, the grant alternates between them, starting with the lower input after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 8 | Per source: a flit is offered |
| inReady | output | 8 | Per source: the fabric takes the flit this edge |
| inFlit | input | 8x27 | Per source: {dest[2:0], payload[15:0], trailer[7:0]} |
| outValid | output | 8 | Per destination: a flit is presented |
| outReady | input | 8 | Per destination: the sink takes the flit this edge |
| outFlit | output | 8x24 | Per destination: {payload[15:0], trailer[7:0]} |

## Verification
Single flits on an idle fabric fix the three-cycle latency and the column-per-bit routing. The identity and complement permutations have no internal conflicts, so any stall during them exposes a wrong pairing or a wrong arbitration. A hotspot pattern sends every source to one destination, and a two-source stream fights over a single stage-one output; these show that losers are held rather than lost, and that grants alternate. A flood with all outputs blocked measures buffer capacity exactly. Random destinations with random sink backpressure, plus a sweep of every source/destination pair, show that no flit is misrouted, reordered or altered while outputs stall.

// File: rtl/bfly_pkg.sv
package bfly_pkg;

  // Strobes from a switch controller to its datapath, one bit per output.
  typedef struct packed {
    logic [1:0] load;  // capture a flit into this output register
    logic [1:0] sel;   // 0: take the lower input, 1: take the upper input
  } swStrobe_t;

  // Lower column of switch pair 'pair' in a stage that pairs columns
  // differing in bit 'bitPos': insert a 0 at that bit position.
  function automatic int lowCol(input int pair, input int bitPos);
    return ((pair >> bitPos) << (bitPos + 1)) | (pair & ((1 << bitPos) - 1));
  endfunction

endpackage

// File: rtl/bfly_sw_ctrl.sv
module bfly_sw_ctrl
  import bfly_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] inValid,
  input  logic [1:0] inBit,     // destination bit this stage resolves
  input  logic [1:0] outReady,
  output logic [1:0] inReady,
  output logic [1:0] outValid,
  output swStrobe_t  strb
);

  logic [1:0] full;    // output register occupied
  logic [1:0] prio;    // preferred input per output when both request
  logic [1:0] space;
  logic [1:0] winner;
  logic [1:0] reqLo;   // lower input requests output o
  logic [1:0] reqHi;   // upper input requests output o

  always_comb begin
    for (int o = 0; o < 2; o++) begin
      reqLo[o] = inValid[0] && (inBit[0] == o[0]);
      reqHi[o] = inValid[1] && (inBit[1] == o[0]);
      space[o] = !full[o] || outReady[o];
      if (reqLo[o] && reqHi[o]) winner[o] = prio[o];
      else                      winner[o] = reqHi[o];
      strb.load[o] = space[o] && (reqLo[o] || reqHi[o]);
      strb.sel[o]  = winner[o];
    end
    for (int i = 0; i < 2; i++) begin
      inReady[i] = strb.load[inBit[i]] && (strb.sel[inBit[i]] == i[0]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      full <= '0;
      prio <= '0;
    end else begin
      for (int o = 0; o < 2; o++) begin
        full[o] <= strb.load[o] | (full[o] & ~outReady[o]);
        if (reqLo[o] && reqHi[o] && space[o]) prio[o] <= ~winner[o];
      end
    end
  end

  assign outValid = full;

endmodule

// File: rtl/bfly_sw_dp.sv
module bfly_sw_dp
  import bfly_pkg::*;
#(
  parameter  int HDR_W  = 3,
  parameter  int BODY_W = 24,
  localparam int FLIT_W = HDR_W + BODY_W
) (
  input  logic                   clk,
  input  swStrobe_t              strb,
  input  logic [1:0][FLIT_W-1:0] inFlit,
  output logic [1:0][FLIT_W-1:0] outFlit
);

  // Drop the resolved header bit so the next stage finds its bit on top.
  function automatic logic [FLIT_W-1:0] advance(input logic [FLIT_W-1:0] f);
    return {f[FLIT_W-1 -: HDR_W] << 1, f[BODY_W-1:0]};
  endfunction

  always_ff @(posedge clk) begin
    for (int o = 0; o < 2; o++) begin
      if (strb.load[o]) outFlit[o] <= advance(inFlit[strb.sel[o]]);
    end
  end

endmodule

// File: rtl/bfly_fabric.sv
module bfly_fabric
  import bfly_pkg::*;
#(
  parameter  int NODES  = 8,
  parameter  int PAY_W  = 16,
  parameter  int TRL_W  = 8,
  localparam int STAGES = $clog2(NODES),
  localparam int BODY_W = PAY_W + TRL_W,
  localparam int FLIT_W = STAGES + BODY_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NODES-1:0]             inValid,
  output logic [NODES-1:0]             inReady,
  input  logic [NODES-1:0][FLIT_W-1:0] inFlit,
  output logic [NODES-1:0]             outValid,
  input  logic [NODES-1:0]             outReady,
  output logic [NODES-1:0][BODY_W-1:0] outFlit
);

  localparam int PAIRS = NODES / 2;

  // Rank 0 is the input edge, rank STAGES the output edge.
  logic              rankValid [STAGES+1][NODES];
  logic              rankReady [STAGES+1][NODES];
  logic [FLIT_W-1:0] rankFlit  [STAGES+1][NODES];

  for (genvar c = 0; c < NODES; c++) begin : gEdge
    assign rankValid[0][c]      = inValid[c];
    assign rankFlit[0][c]       = inFlit[c];
    assign inReady[c]           = rankReady[0][c];
    assign outValid[c]          = rankValid[STAGES][c];
    assign outFlit[c]           = rankFlit[STAGES][c][BODY_W-1:0];
    assign rankReady[STAGES][c] = outReady[c];
  end

  for (genvar s = 1; s <= STAGES; s++) begin : gStage
    localparam int BITPOS = STAGES - s;  // column bit that differs in a pair
    for (genvar p = 0; p < PAIRS; p++) begin : gSw
      localparam int LO = lowCol(p, BITPOS);
      localparam int HI = LO + (1 << BITPOS);

      logic [1:0]             swInValid, swInBit, swInReady;
      logic [1:0]             swOutValid, swOutReady;
      logic [1:0][FLIT_W-1:0] swInFlit, swOutFlit;
      swStrobe_t              strb;

      assign swInValid  = {rankValid[s-1][HI], rankValid[s-1][LO]};
      assign swInBit    = {rankFlit[s-1][HI][FLIT_W-1], rankFlit[s-1][LO][FLIT_W-1]};
      assign swInFlit[0] = rankFlit[s-1][LO];
      assign swInFlit[1] = rankFlit[s-1][HI];
      assign swOutReady = {rankReady[s][HI], rankReady[s][LO]};

      assign rankReady[s-1][LO] = swInReady[0];
      assign rankReady[s-1][HI] = swInReady[1];
      assign rankValid[s][LO]   = swOutValid[0];
      assign rankValid[s][HI]   = swOutValid[1];
      assign rankFlit[s][LO]    = swOutFlit[0];
      assign rankFlit[s][HI]    = swOutFlit[1];

      bfly_sw_ctrl ctrl (
        .clk      (clk),
        .rstN     (rstN),
        .inValid  (swInValid),
        .inBit    (swInBit),
        .outReady (swOutReady),
        .inReady  (swInReady),
        .outValid (swOutValid),
        .strb     (strb)
      );

      bfly_sw_dp #(.HDR_W(STAGES), .BODY_W(BODY_W)) dp (
        .clk     (clk),
        .strb    (strb),
        .inFlit  (swInFlit),
        .outFlit (swOutFlit)
      );
    end
  end

endmodule

// File: rtl/bfly_fabric_chk.sv
module bfly_fabric_chk #(
  parameter  int NODES  = 8,
  parameter  int BODY_W = 24,
  parameter  int STAGES = 3,
  localparam int CAP    = NODES * STAGES,
  localparam int FW     = $clog2(CAP + NODES + 1) + 1
) (
  input logic                         clk,
  input logic                         rstN,
  input logic [NODES-1:0]             inValid,
  input logic [NODES-1:0]             inReady,
  input logic [NODES-1:0]             outValid,
  input logic [NODES-1:0]             outReady,
  input logic [NODES-1:0][BODY_W-1:0] outFlit
);

  logic [FW-1:0] flight;  // flits accepted and not yet delivered

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flight <= '0;
    else flight <= flight + FW'($countones(inValid & inReady))
                          - FW'($countones(outValid & outReady));
  end

  AST_RESET_EMPTY: assert property (@(posedge clk)
    !rstN |=> (outValid == '0)); // R1

  AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    int'(flight) <= CAP); // R9

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outValid & outReady) <= int'(flight)); // R7

  for (genvar p = 0; p < NODES; p++) begin : gPort
    AST_HOLD_STALLED: assert property (@(posedge clk) disable iff (!rstN)
      outValid[p] && !outReady[p] |=> outValid[p] && $stable(outFlit[p])); // R5
  end

endmodule

bind bfly_fabric bfly_fabric_chk #(.NODES(NODES), .BODY_W(BODY_W), .STAGES(STAGES)) chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .outValid (outValid),
  .outReady (outReady),
  .outFlit  (outFlit)
);

// File: tb/bfly_fabric_test.sv
`timescale 1ns/1ps
module bfly_fabric_test;
  localparam int NODES  = 8;
  localparam int BODY_W = 24;
  localparam int FLIT_W = 27;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic [NODES-1:0]             inValid = '0;
  logic [NODES-1:0]             inReady;
  logic [NODES-1:0][FLIT_W-1:0] inFlit = '0;
  logic [NODES-1:0]             outValid;
  logic [NODES-1:0]             outReady = '0;
  logic [NODES-1:0][BODY_W-1:0] outFlit;

  bfly_fabric uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady), .inFlit(inFlit),
    .outValid(outValid), .outReady(outReady), .outFlit(outFlit)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int accCnt = 0;
  int stallCnt = 0;
  int altErr = 0;
  int altPrev = -1;
  bit altOn = 0;
  int readyMode = 0;  // 0 all ready, 1 all blocked, 2 pseudo-random
  logic [15:0] lfsr = 16'hACE1;
  logic [NODES-1:0] fired = '0;
  int acceptCyc [NODES];
  int deliverCyc [NODES];
  logic [NODES-1:0] holdPending = '0;
  logic [BODY_W-1:0] holdFlit [NODES];
  logic [2:0] mSrc;
  logic [BODY_W-1:0] mExp;

  logic [FLIT_W-1:0] srcQ [NODES][$];
  logic [BODY_W-1:0] expQ [NODES*NODES][$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard driver: queue a flit at its source, expected item at its sink.
  task automatic send(input int src, input int dst, input int seq);
    logic [15:0] pay;
    logic [7:0]  trl;
    pay = {src[2:0], seq[12:0]};
    trl = seq[7:0] ^ {dst[2:0], src[2:0], 2'b01};
    srcQ[src].push_back({dst[2:0], pay, trl});
    expQ[dst*NODES + src].push_back({pay, trl});
  endtask

  // Source side: offer queue heads, note which were taken.
  always begin
    @(negedge clk);
    for (int s = 0; s < NODES; s++) begin
      if (fired[s]) void'(srcQ[s].pop_front());
      if (rstN && srcQ[s].size() > 0) begin
        inValid[s] = 1'b1;
        inFlit[s]  = srcQ[s][0];
      end else begin
        inValid[s] = 1'b0;
        inFlit[s]  = '0;
      end
    end
    #1;
    for (int s = 0; s < NODES; s++) begin
      fired[s] = inValid[s] && inReady[s];
      if (fired[s]) begin
        acceptCyc[s] = cyc;
        accCnt++;
      end
      if (inValid[s] && !inReady[s]) stallCnt++;
    end
  end

  // Sink side: drive outReady, check stalled outputs and pop the scoreboard.
  always begin
    @(negedge clk);
    for (int o = 0; o < NODES; o++) begin
      case (readyMode)
        0:       outReady[o] = 1'b1;
        1:       outReady[o] = 1'b0;
        default: outReady[o] = lfsr[o] ^ lfsr[o+7];
      endcase
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    for (int o = 0; o < NODES; o++) begin
      if (holdPending[o]) begin
        tests++;
        if (!(outValid[o] && outFlit[o] == holdFlit[o])) begin
          fails++;
          $display("FAIL R5 port %0d hold: valid=%0b flit=%h expected valid=1 flit=%h",
                   o, outValid[o], outFlit[o], holdFlit[o]);
        end
      end
      holdPending[o] = rstN && outValid[o] && !outReady[o];
      holdFlit[o]    = outFlit[o];
      if (rstN && outValid[o] && outReady[o]) begin
        mSrc = outFlit[o][BODY_W-1 -: 3];
        tests++;
        if (expQ[o*NODES + mSrc].size() == 0) begin
          fails++;
          $display("FAIL R2 R7 port %0d: got flit %h from src %0d, expected none", o, outFlit[o], mSrc);
        end else begin
          mExp = expQ[o*NODES + mSrc].pop_front();
          if (mExp != outFlit[o]) begin
            fails++;
            $display("FAIL R3 R6 port %0d: flit %h expected %h", o, outFlit[o], mExp);
          end
        end
        deliverCyc[o] = cyc;
        if (altOn && o == 0) begin
          if (int'(mSrc) == altPrev) altErr++;
          altPrev = int'(mSrc);
        end
      end
    end
  end

  task automatic drain(input string req, input int limit);
    bit done = 0;
    int n = 0;
    int left = 0;
    while (!done && n < limit) begin
      @(negedge clk);
      #2;
      left = 0;
      for (int s = 0; s < NODES; s++) left += srcQ[s].size();
      for (int k = 0; k < NODES*NODES; k++) left += expQ[k].size();
      done = (left == 0) && (inValid == '0) && (outValid == '0);
      n++;
    end
    check(done, req, "all flits delivered (items left)", left, 0);
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    finishRun();
  end

  initial begin
    int base;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(outValid == '0, "R1", "outValid during reset", int'(outValid), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check(outValid == '0, "R1", "outValid after reset", int'(outValid), 0);

    // R4: lone flits, three-cycle latency, correct column
    send(5, 2, 1);
    drain("R2", 50);
    check(deliverCyc[2] - acceptCyc[5] == 3, "R4", "latency 5->2", deliverCyc[2] - acceptCyc[5], 3);
    send(0, 7, 2);
    drain("R2", 50);
    check(deliverCyc[7] - acceptCyc[0] == 3, "R4", "latency 0->7", deliverCyc[7] - acceptCyc[0], 3);

    // R8: identity then complement permutations stream without stalls
    stallCnt = 0;
    for (int r = 0; r < 4; r++) for (int s = 0; s < NODES; s++) send(s, s, 100 + r);
    drain("R8", 100);
    check(stallCnt == 0, "R8", "stalls on identity", stallCnt, 0);
    stallCnt = 0;
    for (int r = 0; r < 4; r++) for (int s = 0; s < NODES; s++) send(s, s ^ 7, 200 + r);
    drain("R8", 100);
    check(stallCnt == 0, "R8", "stalls on complement", stallCnt, 0);

    // R10: sources 0 and 4 fight for the same stage-one output
    altOn = 1;
    altPrev = -1;
    altErr = 0;
    for (int r = 0; r < 6; r++) begin
      send(0, 0, 300 + r);
      send(4, 0, 300 + r);
    end
    drain("R10", 100);
    altOn = 0;
    check(altErr == 0, "R10", "repeated grants to one source", altErr, 0);

    // R7: hotspot, every source to destination 3
    stallCnt = 0;
    for (int r = 0; r < 3; r++) for (int s = 0; s < NODES; s++) send(s, 3, 400 + r);
    drain("R7", 200);
    check(stallCnt > 0, "R7", "losers stalled at their sources (stall count > 0)", stallCnt, 1);

    // R9: outputs blocked, identity flood fills exactly one slot per switch output
    readyMode = 1;
    base = accCnt;
    for (int r = 0; r < 5; r++) for (int s = 0; s < NODES; s++) send(s, s, 500 + r);
    repeat (20) @(negedge clk);
    #2;
    check(accCnt - base == 24, "R9", "flits admitted while blocked", accCnt - base, 24);
    readyMode = 0;
    drain("R9", 200);

    // R5 R6: random destinations under random backpressure
    readyMode = 2;
    for (int r = 0; r < 25; r++) for (int s = 0; s < NODES; s++) send(s, int'($urandom % NODES), 600 + r);
    drain("R6", 5000);
    readyMode = 0;

    // R2 R3: every source to every destination
    for (int s = 0; s < NODES; s++) for (int d = 0; d < NODES; d++) send(s, d, 800 + d);
    drain("R2", 500);

    finishRun();
  end

endmodule